// File: doc/BRIEF.md
# Bus Target Termination Controller

This block is the responding side of a shared parallel bus with active-low framing and handshake lines. When an initiator opens a transaction whose word address falls inside the target's window, the block claims it, drives its own ready line for every data phase it serves, and decides how the burst ends. It ends a burst in one of three ways. In a disconnect with data, ready and stop are driven together, so the word moves and the burst ends. In a disconnect without data, stop is driven alone, so the phase ends and no word moves. A retry is a stop alone on the first phase, before any word has moved.

The choice depends on three things. The first is a configuration input that selects single-word or burst operation. The second is the last word address of the window, where a burst must end. The third is a local busy input. When a word moves, the block raises a strobe together with the word address for the storage behind it. That storage is not part of this block.

Top module: `tgt_term_ctl`

## Requirements
- R1: One cycle after an address phase (`start_n` low while the block is idle), `claim_n` goes low if `bus_addr` lies within [WIN_BASE, WIN_LAST]. If the address is outside that range, `claim_n`, `tgt_rdy_n` and `halt_n` stay high (deasserted) for the whole transaction.
- R2: With `burst_en` low at the address phase, and no busy, the first data phase drives `tgt_rdy_n`=0 and `halt_n`=0 together, so exactly one word moves.
- R3: With `burst_en` high, every phase that is neither busy nor the window's last word drives `tgt_rdy_n`=0 and `halt_n`=1. Each phase that completes (initiator ready low while target ready low) pulses `data_move` with `data_addr` equal to the start address plus the number of words already moved.
- R4: A data phase whose word address equals WIN_LAST drives `tgt_rdy_n`=0 and `halt_n`=0 (disconnect with data).
- R5: `local_busy` high at the address phase gives a retry. The first phase drives `tgt_rdy_n`=1 and `halt_n`=0, and no word moves in the transaction.
- R6: `local_busy` high at the clock edge where a data phase completes makes the following phase a disconnect without data (`tgt_rdy_n`=1, `halt_n`=0, no `data_move`).
- R7: Once `halt_n` is low, it stays low while `start_n` is low. The phases after it show `tgt_rdy_n`=1. While the initiator holds `init_rdy_n` high, the target's ready and stop outputs do not change.
- R8: In the cycle after a phase completes with `start_n` high, `claim_n`, `tgt_rdy_n` and `halt_n` are all high.
- R9: After reset, `claim_n`, `tgt_rdy_n` and `halt_n` are high, and `data_move` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_n | input | 1 | Initiator framing, low while the transaction has more phases |
| init_rdy_n | input | 1 | Initiator ready, low when the initiator can complete a phase |
| bus_addr | input | AW | Word address, valid in the address phase |
| burst_en | input | 1 | 1 = burst-capable, 0 = single-word, sampled at the claim |
| local_busy | input | 1 | Local storage cannot serve the next phase |
| claim_n | output | 1 | Target claims the transaction (low) |
| tgt_rdy_n | output | 1 | Target ready for the current data phase (low) |
| halt_n | output | 1 | Target requests the end of the burst (low) |
| data_move | output | 1 | A word moves at the coming clock edge |
| data_addr | output | AW | Word address of the moving word |

## Verification
The assertions assume an initiator that keeps the protocol. It raises `start_n` only in a phase where it holds `init_rdy_n` low. After it has seen `halt_n` low, it ends the transaction at its next phase. It keeps `burst_en` steady from the claim to the end. The bench initiator follows these rules by construction. It decides framing for each phase only from outputs seen before that phase, and it inserts wait cycles only while framing stays low. `local_busy` is driven to a fresh value only at the edges that start a phase, so each of its effects lands on a known phase number.

// File: rtl/tgt_term_pkg.sv
`timescale 1ns/1ps
package tgt_term_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_IGNORE = 2'd1,
        ST_DATA   = 2'd2,
        ST_TERM   = 2'd3
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e state;
        logic       claim_n;
        logic       trdy_n;
        logic       halt_n;
        logic       burst;
    } tgt_regs_t;

    // phase encoding {trdy_n, halt_n}; busy > last word > plain burst beat
    function automatic logic [1:0] phase_code(input logic busy, input logic last_word);
        if (busy)
            return 2'b10;
        else if (last_word)
            return 2'b00;
        else
            return 2'b01;
    endfunction

endpackage

// File: rtl/tgt_win.sv
`timescale 1ns/1ps
module tgt_win #(
    parameter int            AW       = 8,
    parameter logic [AW-1:0] WIN_BASE = 'h20,
    parameter logic [AW-1:0] WIN_LAST = 'h27
) (
    input  logic [AW-1:0] addr,
    output logic          in_win,
    output logic          at_last
);
    always_comb begin
        in_win  = (addr >= WIN_BASE) && (addr <= WIN_LAST);
        at_last = (addr == WIN_LAST);
    end
endmodule

// File: rtl/tgt_addr_ctr.sv
`timescale 1ns/1ps
module tgt_addr_ctr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          inc,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] addr_q
);
    logic [AW-1:0] addr_d;

    always_comb begin
        addr_d = addr_q;
        if (load)
            addr_d = load_val;
        else if (inc)
            addr_d = addr_q + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else
            addr_q <= addr_d;
    end

    // R3: each moved word advances the address by one
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (addr_q == $past(addr_q) + AW'(1)));

endmodule

// File: rtl/tgt_term_ctl.sv
`timescale 1ns/1ps
module tgt_term_ctl
    import tgt_term_pkg::*;
#(
    parameter int            AW       = 8,
    parameter logic [AW-1:0] WIN_BASE = 'h20,
    parameter logic [AW-1:0] WIN_LAST = 'h27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_n,
    input  logic          init_rdy_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          burst_en,
    input  logic          local_busy,
    output logic          claim_n,
    output logic          tgt_rdy_n,
    output logic          halt_n,
    output logic          data_move,
    output logic [AW-1:0] data_addr
);
    localparam tgt_regs_t RESET_REGS = '{state: ST_IDLE, claim_n: 1'b1,
                                         trdy_n: 1'b1, halt_n: 1'b1, burst: 1'b0};

    tgt_regs_t     r_q, r_d;
    logic          bus_hit, bus_last;
    logic          nxt_in, nxt_last;
    logic [AW-1:0] addr_q, nxt_addr;
    logic          ctr_load, ctr_inc;
    logic          phase_done;

    assign nxt_addr = addr_q + AW'(1);

    tgt_win #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)) i_win_bus (
        .addr(bus_addr), .in_win(bus_hit), .at_last(bus_last));

    tgt_win #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)) i_win_nxt (
        .addr(nxt_addr), .in_win(nxt_in), .at_last(nxt_last));

    tgt_addr_ctr #(.AW(AW)) i_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .inc(ctr_inc),
        .load_val(bus_addr), .addr_q(addr_q));

    always_comb begin
        phase_done = ((r_q.state == ST_DATA) || (r_q.state == ST_TERM)) &&
                     !init_rdy_n && (!r_q.trdy_n || !r_q.halt_n);
        data_move  = phase_done && !r_q.trdy_n;
        data_addr  = addr_q;
    end

    always_comb begin
        r_d      = r_q;
        ctr_load = 1'b0;
        ctr_inc  = data_move;
        unique case (r_q.state)
            ST_IDLE: begin
                if (!start_n) begin
                    if (bus_hit) begin
                        r_d.state   = ST_DATA;
                        r_d.claim_n = 1'b0;
                        r_d.burst   = burst_en;
                        ctr_load    = 1'b1;
                        {r_d.trdy_n, r_d.halt_n} =
                            phase_code(local_busy, !burst_en || bus_last);
                    end else begin
                        r_d.state = ST_IGNORE;
                    end
                end
            end
            ST_IGNORE: begin
                if (start_n && init_rdy_n)
                    r_d.state = ST_IDLE;
            end
            ST_DATA: begin
                if (phase_done) begin
                    if (start_n) begin
                        r_d = RESET_REGS;
                    end else if (!r_q.halt_n) begin
                        r_d.state  = ST_TERM;
                        r_d.trdy_n = 1'b1;
                        r_d.halt_n = 1'b0;
                    end else begin
                        {r_d.trdy_n, r_d.halt_n} =
                            phase_code(local_busy, !r_q.burst || nxt_last || !nxt_in);
                    end
                end
            end
            ST_TERM: begin
                if (phase_done && start_n)
                    r_d = RESET_REGS;
            end
            default: r_d = RESET_REGS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= RESET_REGS;
        else
            r_q <= r_d;
    end

    assign claim_n   = r_q.claim_n;
    assign tgt_rdy_n = r_q.trdy_n;
    assign halt_n    = r_q.halt_n;

    p_claim_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !start_n && bus_hit) |=> !claim_n);

    p_no_claim_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !start_n && !bus_hit) |=> claim_n);

    p_single_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim_n && !r_q.burst && !tgt_rdy_n) |-> !halt_n);

    p_last_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_move && data_addr == WIN_LAST) |-> !halt_n);

    p_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !start_n && bus_hit && local_busy) |=> (tgt_rdy_n && !halt_n));

    p_busy_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_move && halt_n && !start_n && local_busy) |=> (tgt_rdy_n && !halt_n));

    p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim_n && !halt_n && !start_n) |=> !halt_n);

    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim_n && init_rdy_n) |=> ($stable(tgt_rdy_n) && $stable(halt_n)));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_done && start_n) |=> (claim_n && tgt_rdy_n && halt_n));

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        claim_n |-> (tgt_rdy_n && halt_n && !data_move));

endmodule

// File: tb/test_tgt_term_ctl.sv
`timescale 1ns/1ps
module test_tgt_term_ctl;
    localparam int AW       = 8;
    localparam int WIN_BASE = 'h20;
    localparam int WIN_LAST = 'h27;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_n = 1'b1;
    logic          init_rdy_n = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          burst_en = 1'b0;
    logic          local_busy = 1'b0;
    logic          claim_n, tgt_rdy_n, halt_n, data_move;
    logic [AW-1:0] data_addr;

    int  total = 0;
    int  bad = 0;
    int  cycles = 0;
    bit  finished = 0;

    always #10 clk = ~clk;

    tgt_term_ctl #(.AW(AW), .WIN_BASE(AW'(WIN_BASE)), .WIN_LAST(AW'(WIN_LAST))) i_tgt_term_ctl (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .init_rdy_n(init_rdy_n),
        .bus_addr(bus_addr), .burst_en(burst_en), .local_busy(local_busy),
        .claim_n(claim_n), .tgt_rdy_n(tgt_rdy_n), .halt_n(halt_n),
        .data_move(data_move), .data_addr(data_addr));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_txn(input int a, input int len, input int busyat, input bit iw, input bit bm);
        int    done_ph = 0;
        int    moved = 0;
        int    ea = a;
        int    exp_moved;
        bit    stop_seen = 0;
        bit    fin = 0;
        bit    hit;
        bit    last;
        bit    et, es;
        string tag;
        logic [1:0] sv;
        hit = (a >= WIN_BASE) && (a <= WIN_LAST);
        @(negedge clk);
        burst_en   = bm;
        start_n    = 1'b0;
        bus_addr   = AW'(a);
        init_rdy_n = 1'b1;
        local_busy = (busyat == 0);
        @(negedge clk);
        chk(claim_n == !hit, "R1 claim", int'(claim_n), int'(!hit));
        if (!hit) begin
            start_n    = 1'b1;
            init_rdy_n = 1'b0;
            local_busy = 1'b0;
            @(negedge clk);
            chk(claim_n && tgt_rdy_n && halt_n, "R1 outside stays quiet",
                int'({claim_n, tgt_rdy_n, halt_n}), 7);
            init_rdy_n = 1'b1;
            @(negedge clk);
            return;
        end
        while (!fin && done_ph < 12) begin
            if (iw) begin
                init_rdy_n = 1'b1;
                sv = {tgt_rdy_n, halt_n};
                @(negedge clk);
                chk({tgt_rdy_n, halt_n} == sv, "R7 wait hold",
                    int'({tgt_rdy_n, halt_n}), int'(sv));
            end
            last       = (done_ph + 1 >= len) || stop_seen;
            start_n    = last;
            init_rdy_n = 1'b0;
            local_busy = (busyat == done_ph + 1);
            #1;
            if (stop_seen) begin
                et = 1; es = 0; tag = "R7 stop held";
            end else if (busyat == done_ph) begin
                et = 1; es = 0; tag = (done_ph == 0) ? "R5 retry" : "R6 disconnect no data";
            end else if (!bm) begin
                et = 0; es = 0; tag = "R2 single word";
            end else if (ea == WIN_LAST) begin
                et = 0; es = 0; tag = "R4 last word";
            end else begin
                et = 0; es = 1; tag = "R3 burst beat";
            end
            chk(tgt_rdy_n == et && halt_n == es, tag,
                int'({tgt_rdy_n, halt_n}), int'({et, es}));
            chk(data_move == !et, "R3 move strobe", int'(data_move), int'(!et));
            if (data_move)
                chk(int'(data_addr) == ea, "R3 word address", int'(data_addr), ea);
            if (!tgt_rdy_n) begin
                ea++;
                moved++;
            end
            if (!halt_n) stop_seen = 1;
            @(negedge clk);
            done_ph++;
            if (last) begin
                fin = 1;
                chk(claim_n && tgt_rdy_n && halt_n, "R8 release",
                    int'({claim_n, tgt_rdy_n, halt_n}), 7);
                init_rdy_n = 1'b1;
                start_n    = 1'b1;
                local_busy = 1'b0;
            end
        end
        if (busyat == 0) exp_moved = 0;
        else if (!bm) exp_moved = 1;
        else begin
            exp_moved = len;
            if (WIN_LAST - a + 1 < exp_moved) exp_moved = WIN_LAST - a + 1;
            if (busyat > 0 && busyat < exp_moved) exp_moved = busyat;
        end
        chk(moved == exp_moved, "R3 word count", moved, exp_moved);
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                finished = 1;
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(claim_n && tgt_rdy_n && halt_n && !data_move, "R9 reset state",
            int'({claim_n, tgt_rdy_n, halt_n, data_move}), 14);
        for (int bm = 0; bm < 2; bm++)
            for (int a = WIN_BASE - 2; a <= WIN_LAST + 1; a++)
                for (int len = 1; len <= 4; len++)
                    for (int busyat = -1; busyat <= 3; busyat++)
                        for (int iw = 0; iw < 2; iw++)
                            run_txn(a, len, busyat, iw[0], bm[0]);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule